// File: doc/BRIEF.md
# Control Endpoint Status Interlock

This block holds the status and mode byte of a USB device's control endpoint. Two parties share it: firmware, through read and write strobes, and the serial interface engine (SIE), through single-cycle event strobes. The SIE marks the kind of token that just finished its token phase, whether the transaction finished with a handshake acknowledge, and the window in which a SETUP packet's data and handshake are in flight. Firmware sets the four-bit response mode and clears the flags once it has handled them.

When the SIE writes the register, the low seven bits become closed to firmware writes. They stay closed until firmware reads the register. Firmware should therefore read back after every write to see whether the write took effect. The block also holds a small byte buffer for the endpoint. Firmware writes into this buffer are refused while a SETUP is pending, so that an arriving SETUP packet cannot be overwritten before firmware has read it.

Top module: `ctl_ep_status`

## Requirements
- R1: After reset, `status` is 0x00 and `locked` is 0.
- R2: A token strobe (`sie_setup`, `sie_in` or `sie_out`) writes `status[7:5]` with the one-hot token kind in the next cycle: SETUP is 3'b100, IN is 3'b010, OUT is 3'b001. Bits [4:0] are left unchanged.
- R3: `sie_ack` sets `status[4]` to 1 in the next cycle. The other bits keep their values unless a token strobe arrives in the same cycle.
- R4: Any SIE strobe (token or ack) sets `locked`. While `locked` is 1, a firmware write leaves `status[6:0]` unchanged.
- R5: When no SIE strobe arrives in the same cycle, a firmware read clears `locked` for the next cycle. A firmware write while unlocked loads `cpu_wdata[6:0]` into `status[6:0]`; bits [3:0] are the response mode.
- R6: Outside a SETUP hold window, any firmware write clears `status[7]`, whether or not the register is locked. Firmware can never set bit 7.
- R7: From `sie_data_start` until `sie_hs_start`, `status[7]` reads 1 and a firmware write cannot clear it. Writes to the unlocked bits [6:0] still take effect during this window.
- R8: If a firmware write and an SIE strobe fall in the same cycle, the SIE result is stored, the write is discarded and `locked` is set.
- R9: `buf_wr_ok` is high exactly when `buf_wr` is high and `status[7]` is 0. A refused write leaves the buffer contents unchanged.
- R10: An accepted buffer write is read back on `buf_rdata` at the same address from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Firmware read strobe of the status register; releases the lock |
| cpu_wr | input | 1 | Firmware write strobe of the status register |
| cpu_wdata | input | 7 | Write data for bits [6:0] |
| status | output | 8 | Register value: bit7 SETUP, bit6 IN, bit5 OUT, bit4 ACK, [3:0] mode |
| locked | output | 1 | Bits [6:0] are closed to firmware writes |
| sie_setup | input | 1 | SETUP token phase finished |
| sie_in | input | 1 | IN token phase finished |
| sie_out | input | 1 | OUT token phase finished |
| sie_ack | input | 1 | Transaction finished with an ACK |
| sie_data_start | input | 1 | SETUP data phase begins |
| sie_hs_start | input | 1 | SIE handshake packet begins |
| buf_wr | input | 1 | Firmware write strobe into the endpoint buffer |
| buf_waddr | input | AW | Buffer write address |
| buf_wdata | input | DW | Buffer write byte |
| buf_wr_ok | output | 1 | Buffer write accepted this cycle |
| buf_raddr | input | AW | Buffer read address |
| buf_rdata | output | DW | Buffer byte at `buf_raddr` |

## Verification
The assertions assume that the SIE behaves as a protocol engine does. At most one token strobe is active per cycle. `sie_data_start` never coincides with a token strobe or with `sie_hs_start`. Inside a SETUP hold window no IN or OUT token arrives. The stimulus follows the order a real SETUP transaction takes: token, then data start, then handshake start, then ack. Firmware traffic is placed between these events or in the same cycle as them, which creates the races of R8 without breaking those input rules.

// File: rtl/ctl_ep_status.sv
module ctl_ep_status #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [6:0]    cpu_wdata,
  output logic [7:0]    status,
  output logic          locked,
  input  logic          sie_setup,
  input  logic          sie_in,
  input  logic          sie_out,
  input  logic          sie_ack,
  input  logic          sie_data_start,
  input  logic          sie_hs_start,
  input  logic          buf_wr,
  input  logic [AW-1:0] buf_waddr,
  input  logic [DW-1:0] buf_wdata,
  output logic          buf_wr_ok,
  input  logic [AW-1:0] buf_raddr,
  output logic [DW-1:0] buf_rdata
);

  logic [7:0]    stat_q;
  logic          lock_q;
  logic          hold_q;
  logic [DW-1:0] mem [DEPTH];

  wire tok     = sie_setup | sie_in | sie_out;
  wire sie_upd = tok | sie_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      lock_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (sie_upd) begin
        if (tok) stat_q[7:5] <= {sie_setup, sie_in, sie_out};
        if (sie_ack) stat_q[4] <= 1'b1;
        lock_q <= 1'b1;
      end else begin
        if (cpu_wr) begin
          if (!lock_q) stat_q[6:0] <= cpu_wdata;
          if (!hold_q) stat_q[7] <= 1'b0;
        end
        if (cpu_rd) lock_q <= 1'b0;
      end
      if (sie_data_start) begin
        hold_q    <= 1'b1;
        stat_q[7] <= 1'b1;
      end else if (sie_hs_start) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign buf_wr_ok = buf_wr & ~stat_q[7];

  always_ff @(posedge clk)
    if (buf_wr_ok) mem[buf_waddr] <= buf_wdata;

  assign buf_rdata = mem[buf_raddr];
  assign status    = stat_q;
  assign locked    = lock_q;

endmodule

// File: rtl/ctl_ep_status_chk.sv
module ctl_ep_status_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          sie_setup,
  input logic          sie_in,
  input logic          sie_out,
  input logic          sie_ack,
  input logic          sie_data_start,
  input logic          hold,
  input logic [7:0]    status,
  input logic          locked,
  input logic          buf_wr,
  input logic          buf_wr_ok,
  input logic [AW-1:0] buf_waddr,
  input logic [AW-1:0] buf_raddr,
  input logic [DW-1:0] buf_wdata,
  input logic [DW-1:0] buf_rdata
);

  wire upd = sie_setup | sie_in | sie_out | sie_ack;

  AST_SETUP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup |=> status[7:5] == 3'b100); // R2
  AST_IN_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_in && !sie_data_start) |=> status[7:5] == 3'b010); // R2
  AST_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sie_ack |=> status[4]); // R3
  AST_LOCK_ON_SIE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> locked); // R8
  AST_LOCKED_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cpu_wr && !upd) |=> status[6:0] == $past(status[6:0])); // R4
  AST_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !upd) |=> !locked); // R5
  AST_WRITE_CLEARS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !upd && !hold && !sie_data_start) |=> !status[7]); // R6
  AST_HOLD_KEEPS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> status[7]); // R7
  AST_REFUSED_BUF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && status[7] && buf_waddr == buf_raddr)
      |=> (buf_raddr != $past(buf_raddr)) || (buf_rdata == $past(buf_rdata))); // R9
  AST_BUF_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_ok && buf_waddr == buf_raddr)
      |=> (buf_raddr != $past(buf_raddr)) || (buf_rdata == $past(buf_wdata))); // R10

endmodule

bind ctl_ep_status ctl_ep_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .sie_setup(sie_setup), .sie_in(sie_in), .sie_out(sie_out), .sie_ack(sie_ack),
  .sie_data_start(sie_data_start), .hold(hold_q), .status(status), .locked(locked),
  .buf_wr(buf_wr), .buf_wr_ok(buf_wr_ok), .buf_waddr(buf_waddr),
  .buf_raddr(buf_raddr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
);

// File: tb/sim_ctl_ep_status.sv
`timescale 1ns/1ps
module sim_ctl_ep_status;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [6:0] cpu_wdata = '0;
  logic sie_setup = 0, sie_in = 0, sie_out = 0, sie_ack = 0;
  logic sie_data_start = 0, sie_hs_start = 0;
  logic buf_wr = 0;
  logic [AW-1:0] buf_waddr = '0, buf_raddr = '0;
  logic [DW-1:0] buf_wdata = '0;
  logic [7:0] status;
  logic locked, buf_wr_ok;
  logic [DW-1:0] buf_rdata;

  always #10 clk = ~clk;

  ctl_ep_status #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .status(status), .locked(locked), .sie_setup(sie_setup), .sie_in(sie_in),
    .sie_out(sie_out), .sie_ack(sie_ack), .sie_data_start(sie_data_start),
    .sie_hs_start(sie_hs_start), .buf_wr(buf_wr), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .buf_wr_ok(buf_wr_ok), .buf_raddr(buf_raddr),
    .buf_rdata(buf_rdata)
  );

  typedef struct {
    logic [7:0]    st;
    logic          lk;
    logic [DW-1:0] rd;
    string         req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;

  logic [7:0] m_st = '0;
  logic m_lk = 0, m_hold = 0;
  logic [DW-1:0] m_mem [DEPTH];

  function automatic void report(string req, string what, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp_v);
    end
  endfunction

  task automatic op(input logic rd, input logic wr, input logic [6:0] wd,
                    input logic s, input logic i, input logic o, input logic a,
                    input logic ds, input logic hs,
                    input logic bw, input logic [AW-1:0] wa, input logic [DW-1:0] bd,
                    input logic [AW-1:0] ra, input string req);
    item_t it;
    logic acc;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
    sie_setup = s; sie_in = i; sie_out = o; sie_ack = a;
    sie_data_start = ds; sie_hs_start = hs;
    buf_wr = bw; buf_waddr = wa; buf_wdata = bd; buf_raddr = ra;
    acc = bw && !m_st[7];
    #1 report(req, "buf_wr_ok", int'(buf_wr_ok), int'(acc));
    @(posedge clk);
    if (acc) m_mem[wa] = bd;
    if (s | i | o | a) begin
      if (s | i | o) m_st[7:5] = {s, i, o};
      if (a) m_st[4] = 1'b1;
      m_lk = 1'b1;
    end else begin
      if (wr) begin
        if (!m_lk) m_st[6:0] = wd;
        if (!m_hold) m_st[7] = 1'b0;
      end
      if (rd) m_lk = 1'b0;
    end
    if (ds) begin m_hold = 1'b1; m_st[7] = 1'b1; end
    else if (hs) m_hold = 1'b0;
    #1;
    it.st = m_st; it.lk = m_lk; it.rd = m_mem[ra]; it.req = req;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        report(it.req, "status", int'(status), int'(it.st));
        report(it.req, "locked", int'(locked), int'(it.lk));
        report(it.req, "buf_rdata", int'(buf_rdata), int'(it.rd));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report("R1", "status", int'(status), 0);
    report("R1", "locked", int'(locked), 0);
    // preload buffer so read data is defined
    for (int k = 0; k < DEPTH; k++)
      op(0,0,7'h00, 0,0,0,0, 0,0, 1,AW'(k),8'h00, AW'(k), "R10");
    rst_n = 1'b1;
    op(0,1,7'h0B, 0,0,0,0, 0,0, 0,0,0, 0, "R5");
    op(0,0,7'h00, 0,1,0,0, 0,0, 0,0,0, 0, "R2");
    op(0,1,7'h05, 0,0,0,0, 0,0, 0,0,0, 0, "R4");
    op(1,0,7'h00, 0,0,0,0, 0,0, 0,0,0, 0, "R5");
    op(0,1,7'h03, 0,0,0,0, 0,0, 0,0,0, 0, "R5");
    op(0,1,7'h7F, 0,0,1,0, 0,0, 0,0,0, 0, "R8");
    op(0,0,7'h00, 0,0,0,1, 0,0, 0,0,0, 0, "R3");
    op(1,0,7'h00, 0,0,0,0, 0,0, 0,0,0, 0, "R5");
    op(0,0,7'h00, 0,0,0,0, 0,0, 1,3'd2,8'hA5, 3'd2, "R10");
    op(0,0,7'h00, 1,0,0,0, 0,0, 0,0,0, 3'd2, "R2");
    op(0,0,7'h00, 0,0,0,0, 0,0, 1,3'd2,8'h5A, 3'd2, "R9");
    op(0,0,7'h00, 0,0,0,0, 1,0, 0,0,0, 3'd2, "R7");
    op(0,1,7'h00, 0,0,0,0, 0,0, 0,0,0, 3'd2, "R7");
    op(1,0,7'h00, 0,0,0,0, 0,0, 1,3'd4,8'h77, 3'd4, "R9");
    op(0,1,7'h01, 0,0,0,0, 0,0, 0,0,0, 0, "R7");
    op(0,0,7'h00, 0,0,0,0, 0,1, 0,0,0, 0, "R7");
    op(0,0,7'h00, 0,0,0,1, 0,0, 0,0,0, 0, "R3");
    op(0,1,7'h00, 0,0,0,0, 0,0, 0,0,0, 0, "R6");
    op(0,0,7'h00, 0,0,0,0, 0,0, 1,3'd5,8'h3C, 3'd5, "R10");
    op(1,0,7'h00, 0,0,0,0, 0,0, 0,0,0, 3'd2, "R10");
    op(0,0,7'h00, 0,0,0,0, 0,0, 0,0,0, 3'd4, "R9");
    repeat (3) @(posedge clk);
    #5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule